// File: doc/BRIEF.md
# Word Programming Sequencer for UV/OTP Parallel Memories

This block runs the programmer side of a pulse-and-verify write flow for a parallel, word-wide, ultraviolet-erasable or one-time-programmable memory. After `start`, it raises the high programming supply and selects the elevated programming core supply. It then works through every address in turn. Each address gets one fixed-width active-low program strobe, after which the sequencer releases the data bus and reads the word back. If the word matches, the sequencer moves to the next address at once. If it does not match, another strobe follows. The run stops with a fail result when a word has received the maximum number of strobes and still does not verify.

Once the last address has programmed, the high supply is dropped. Every word is then read back and compared against the expected pattern, once at the 5 V core setting and once at the 2.7 V setting. The result shows on `done` (pass) or `fail` and stays there until the next `start`. The word to program at the current address is supplied combinationally on `pat_i` by the surrounding logic. All microsecond intervals are counted by one shared down-counter whose lengths are scaled from the `CLK_MHZ` parameter. The supply-select outputs only choose levels; generating the voltages is done elsewhere.

Top module: `eps_prog_seq`

## Requirements
- R1: Out of reset and while idle: `ce_n`, `oe_n` and `pgm_n` are 1, `data_oe` and `vpp_hi` are 0, `vcc_sel` is 2'b00 (nominal), and `busy`, `done` and `fail` are 0. At most one of `busy`, `done` and `fail` is high at any time. `busy` is high from the cycle after `start` until the result appears.
- R2: Every program strobe (`pgm_n` low) lasts exactly 100*CLK_MHZ clock cycles, which is 100 µs and therefore inside the 95 to 105 µs window.
- R3: `pgm_n` is low only while all of the following hold: `ce_n`=0, `oe_n`=1, `vpp_hi`=1, `vcc_sel`=2'b01 (programming level), `data_oe`=1 and `data_o` equal to `pat_i`.
- R4: Before `pgm_n` falls, address, data, `ce_n` low, `vpp_hi` high and `data_oe` high have all been stable for at least 2*CLK_MHZ cycles. Address and data do not change while the strobe is low. Data stays driven, unchanged, for at least 2*CLK_MHZ cycles after `pgm_n` rises.
- R5: After each strobe, `data_oe` drops at least 2*CLK_MHZ cycles before `oe_n` falls for the verify read. `oe_n` is never low while `data_oe` is 1. The read data is compared at the end of ceil(CLK_MHZ*100/1000) cycles of `oe_n` low.
- R6: A verify match moves on to the next address with no further strobe at the matched address, and the strobe count restarts at zero. A word that needs k strobes (1 ≤ k ≤ MAX_PULSES) therefore receives exactly k.
- R7: If a word still mismatches after its MAX_PULSES-th strobe (default 25), the run ends with `fail`=1 and `done`=0. No later address receives a strobe and no check read takes place.
- R8: After the last address verifies, `vpp_hi` drops and every word is read in ascending address order, first with `vcc_sel`=2'b10 (5 V) and then with `vcc_sel`=2'b11 (2.7 V). If all reads match, `done`=1.
- R9: Any mismatch during either check pass ends the run at once with `fail`=1. No further word is read.
- R10: `start` is ignored while `busy` is high. `start` given after a result begins a fresh run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a run when not busy |
| pat_i | input | DATA_W | Word to program at `addr_o` |
| data_i | input | DATA_W | Data bus as read from the memory |
| addr_o | output | ADDR_W | Memory address |
| data_o | output | DATA_W | Data driven onto the bus |
| data_oe | output | 1 | Bus drive enable (0 = released) |
| ce_n | output | 1 | Chip enable, active low |
| oe_n | output | 1 | Output enable, active low |
| pgm_n | output | 1 | Program strobe, active low |
| vpp_hi | output | 1 | Selects the high programming supply |
| vcc_sel | output | 2 | Core supply: 00 nominal, 01 program, 10 5 V, 11 2.7 V |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run ended with all words correct |
| fail | output | 1 | Run ended with an error |

## Verification
The bench uses CLK_MHZ=1, so one verify attempt is 2 setup cycles, a 100-cycle strobe, 2 hold cycles, 2 release cycles and a 1-cycle read. A behavioural memory model on the bench side sets a word to its pattern only after a chosen number of strobes at that address. The model samples every control output on the falling clock edge. It measures strobe widths, setup, hold and release windows in cycles since the relevant edge, and records the address of each check read against the expected ascending order. Final results are checked only after `done` or `fail` is seen at a falling edge. This is one cycle after the last compare, because the result is a state register. Strobe counts per address, read counts per supply level and the array contents are then compared with values computed from the chosen strobe needs and fault positions.

// File: rtl/eps_pkg.sv
// Package: shared state and supply-select encodings for the programming sequencer.
// Assumes nothing beyond a 2-bit supply-select field decoded by the supply logic.
package eps_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETUP,
        ST_PULSE,
        ST_HOLD,
        ST_RELEASE,
        ST_VERIFY,
        ST_SETTLE,
        ST_CHECK,
        ST_PASS,
        ST_FAIL
    } eps_state_e;

    localparam logic [1:0] SUP_NOMINAL = 2'b00;
    localparam logic [1:0] SUP_PROGRAM = 2'b01;
    localparam logic [1:0] SUP_HIGH    = 2'b10;
    localparam logic [1:0] SUP_LOW     = 2'b11;

endpackage

// File: rtl/eps_interval_timer.sv
// Shared down-counter for every timed interval of the sequencer.
// Loading N-1 makes `expired` rise N cycles later, counting the load cycle's successor as cycle 1.
// Assumes the owner reloads it on every state change that needs a new interval.
module eps_interval_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] value,
    output logic         expired
);
    logic [W-1:0] cnt;

    // Count down to zero, or take a new interval length.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= value;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/eps_pulse_tally.sv
// Counts program strobes given to the current word and flags the retry limit.
// Assumes `clear` and `bump` never coincide.
module eps_pulse_tally #(
    parameter int MAX_PULSES = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic bump,
    output logic at_limit
);
    localparam int CW = $clog2(MAX_PULSES + 1);

    logic [CW-1:0] count;

    // Restart per word, count each finished strobe, saturate at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (clear)
            count <= '0;
        else if (bump && !at_limit)
            count <= count + 1'b1;
    end

    assign at_limit = (count == CW'(MAX_PULSES));
endmodule

// File: rtl/eps_prog_seq.sv
// Top of the pulse-and-verify programming sequencer.
// Walks all 2**ADDR_W words: setup, one fixed strobe, hold, bus release, verify read,
// retry up to MAX_PULSES, then reads the whole array at the 5 V and 2.7 V settings.
// Assumes pat_i is valid combinationally for addr_o and data_i is the bus as seen.
module eps_prog_seq
    import eps_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int DATA_W     = 16,
    parameter int CLK_MHZ    = 125,
    parameter int MAX_PULSES = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] pat_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe,
    output logic              ce_n,
    output logic              oe_n,
    output logic              pgm_n,
    output logic              vpp_hi,
    output logic [1:0]        vcc_sel,
    output logic              busy,
    output logic              done,
    output logic              fail
);
    localparam int PULSE_CYC = 100 * CLK_MHZ;
    localparam int GAP_CYC   = 2 * CLK_MHZ;
    localparam int ACC_RAW   = (CLK_MHZ * 100 + 999) / 1000;
    localparam int ACC_CYC   = (ACC_RAW < 1) ? 1 : ACC_RAW;
    localparam int TW        = $clog2(PULSE_CYC + 1);
    localparam logic [TW-1:0] LD_PULSE = TW'(PULSE_CYC - 1);
    localparam logic [TW-1:0] LD_GAP   = TW'(GAP_CYC - 1);
    localparam logic [TW-1:0] LD_ACC   = TW'(ACC_CYC - 1);
    localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

    eps_state_e        state, nxt;
    logic              low_phase;
    logic              tmr_load, tmr_exp;
    logic [TW-1:0]     tmr_val;
    logic              tly_clear, tly_bump, tly_limit;
    logic              adr_zero, adr_inc, phase_low_set, phase_clr;
    logic              match, last;

    eps_interval_timer #(.W(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .value   (tmr_val),
        .expired (tmr_exp)
    );

    eps_pulse_tally #(.MAX_PULSES(MAX_PULSES)) u_tally (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (tly_clear),
        .bump     (tly_bump),
        .at_limit (tly_limit)
    );

    assign match = (data_i == pat_i);
    assign last  = (addr_o == LAST_ADDR);

    // Next-state decision together with timer, tally and address actions.
    always_comb begin
        nxt           = state;
        tmr_load      = 1'b0;
        tmr_val       = '0;
        tly_clear     = 1'b0;
        tly_bump      = 1'b0;
        adr_zero      = 1'b0;
        adr_inc       = 1'b0;
        phase_low_set = 1'b0;
        phase_clr     = 1'b0;
        case (state)
            ST_IDLE, ST_PASS, ST_FAIL: begin
                if (start) begin
                    nxt       = ST_SETUP;
                    tmr_load  = 1'b1;
                    tmr_val   = LD_GAP;
                    tly_clear = 1'b1;
                    adr_zero  = 1'b1;
                    phase_clr = 1'b1;
                end
            end
            ST_SETUP: begin
                if (tmr_exp) begin
                    nxt      = ST_PULSE;
                    tmr_load = 1'b1;
                    tmr_val  = LD_PULSE;
                end
            end
            ST_PULSE: begin
                if (tmr_exp) begin
                    nxt      = ST_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = LD_GAP;
                    tly_bump = 1'b1;
                end
            end
            ST_HOLD: begin
                if (tmr_exp) begin
                    nxt      = ST_RELEASE;
                    tmr_load = 1'b1;
                    tmr_val  = LD_GAP;
                end
            end
            ST_RELEASE: begin
                if (tmr_exp) begin
                    nxt      = ST_VERIFY;
                    tmr_load = 1'b1;
                    tmr_val  = LD_ACC;
                end
            end
            ST_VERIFY: begin
                if (tmr_exp) begin
                    if (match) begin
                        tmr_load = 1'b1;
                        tmr_val  = LD_GAP;
                        if (last) begin
                            nxt      = ST_SETTLE;
                            adr_zero = 1'b1;
                        end else begin
                            nxt       = ST_SETUP;
                            adr_inc   = 1'b1;
                            tly_clear = 1'b1;
                        end
                    end else if (tly_limit) begin
                        nxt = ST_FAIL;
                    end else begin
                        nxt      = ST_SETUP;
                        tmr_load = 1'b1;
                        tmr_val  = LD_GAP;
                    end
                end
            end
            ST_SETTLE: begin
                if (tmr_exp) begin
                    nxt      = ST_CHECK;
                    tmr_load = 1'b1;
                    tmr_val  = LD_ACC;
                end
            end
            ST_CHECK: begin
                if (tmr_exp) begin
                    if (!match) begin
                        nxt = ST_FAIL;
                    end else if (last) begin
                        if (!low_phase) begin
                            nxt           = ST_SETTLE;
                            tmr_load      = 1'b1;
                            tmr_val       = LD_GAP;
                            adr_zero      = 1'b1;
                            phase_low_set = 1'b1;
                        end else begin
                            nxt = ST_PASS;
                        end
                    end else begin
                        adr_inc  = 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = LD_ACC;
                    end
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // State, address and check-phase registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            addr_o    <= '0;
            low_phase <= 1'b0;
        end else begin
            state <= nxt;
            if (adr_zero)
                addr_o <= '0;
            else if (adr_inc)
                addr_o <= addr_o + 1'b1;
            if (phase_clr)
                low_phase <= 1'b0;
            else if (phase_low_set)
                low_phase <= 1'b1;
        end
    end

    // Pin decode from the registered state.
    always_comb begin
        ce_n    = 1'b1;
        oe_n    = 1'b1;
        pgm_n   = 1'b1;
        data_oe = 1'b0;
        vpp_hi  = 1'b0;
        vcc_sel = SUP_NOMINAL;
        case (state)
            ST_SETUP, ST_HOLD: begin
                ce_n = 1'b0; data_oe = 1'b1; vpp_hi = 1'b1; vcc_sel = SUP_PROGRAM;
            end
            ST_PULSE: begin
                ce_n = 1'b0; data_oe = 1'b1; vpp_hi = 1'b1; vcc_sel = SUP_PROGRAM;
                pgm_n = 1'b0;
            end
            ST_RELEASE: begin
                ce_n = 1'b0; vpp_hi = 1'b1; vcc_sel = SUP_PROGRAM;
            end
            ST_VERIFY: begin
                ce_n = 1'b0; oe_n = 1'b0; vpp_hi = 1'b1; vcc_sel = SUP_PROGRAM;
            end
            ST_SETTLE: begin
                ce_n = 1'b0; vcc_sel = low_phase ? SUP_LOW : SUP_HIGH;
            end
            ST_CHECK: begin
                ce_n = 1'b0; oe_n = 1'b0; vcc_sel = low_phase ? SUP_LOW : SUP_HIGH;
            end
            default: ;
        endcase
    end

    assign data_o = data_oe ? pat_i : '0;
    assign busy   = (state != ST_IDLE) && (state != ST_PASS) && (state != ST_FAIL);
    assign done   = (state == ST_PASS);
    assign fail   = (state == ST_FAIL);
endmodule

// File: rtl/eps_prog_seq_chk.sv
// Checker for eps_prog_seq: pin-level timing and exclusivity properties.
// Assumes it is bound to the top and sees its ports unchanged.
module eps_prog_seq_chk #(
    parameter int ADDR_W  = 17,
    parameter int DATA_W  = 16,
    parameter int CLK_MHZ = 125
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr_o,
    input logic [DATA_W-1:0] data_o,
    input logic              data_oe,
    input logic              ce_n,
    input logic              oe_n,
    input logic              pgm_n,
    input logic              vpp_hi,
    input logic [1:0]        vcc_sel,
    input logic              busy,
    input logic              done,
    input logic              fail
);
    localparam int PULSE_CYC = 100 * CLK_MHZ;
    localparam int RW = $clog2(PULSE_CYC + 2);

    logic [RW-1:0] low_run;

    // Length of the current or just-ended strobe in cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)
            low_run <= '0;
        else if (pgm_n)
            low_run <= '0;
        else
            low_run <= low_run + 1'b1;
    end

    a_r1_one_status: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({busy, done, fail}) <= 1);

    a_r2_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pgm_n) |-> (low_run == RW'(PULSE_CYC)));

    a_r3_pulse_conditions: assert property (@(posedge clk) disable iff (!rst_n)
        !pgm_n |-> (!ce_n && oe_n && vpp_hi && data_oe && vcc_sel == 2'b01));

    a_r4_stable_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (!pgm_n && $past(!pgm_n)) |-> ($stable(addr_o) && $stable(data_o)));

    a_r5_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> !data_oe);

    a_r8_check_supply: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n && !vpp_hi) |-> vcc_sel[1]);
endmodule

bind eps_prog_seq eps_prog_seq_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .CLK_MHZ (CLK_MHZ)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr_o  (addr_o),
    .data_o  (data_o),
    .data_oe (data_oe),
    .ce_n    (ce_n),
    .oe_n    (oe_n),
    .pgm_n   (pgm_n),
    .vpp_hi  (vpp_hi),
    .vcc_sel (vcc_sel),
    .busy    (busy),
    .done    (done),
    .fail    (fail)
);

// File: tb/tb_eps_prog_seq.sv
// Bench: behavioural memory with per-word strobe needs, pin timing monitor, five runs.
module tb_eps_prog_seq;
    localparam int AW = 3;
    localparam int NW = 8;
    localparam int DW = 16;
    localparam int CLKM = 1;
    localparam int MAXP = 25;
    localparam int PCYC = 100 * CLKM;
    localparam int GCYC = 2 * CLKM;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [DW-1:0] pat_i, data_i, data_o;
    logic [AW-1:0] addr_o;
    logic data_oe, ce_n, oe_n, pgm_n, vpp_hi, busy, done, fail;
    logic [1:0] vcc_sel;

    always #4 clk = ~clk;

    eps_prog_seq #(.ADDR_W(AW), .DATA_W(DW), .CLK_MHZ(CLKM), .MAX_PULSES(MAXP)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .pat_i(pat_i), .data_i(data_i),
        .addr_o(addr_o), .data_o(data_o), .data_oe(data_oe), .ce_n(ce_n), .oe_n(oe_n),
        .pgm_n(pgm_n), .vpp_hi(vpp_hi), .vcc_sel(vcc_sel), .busy(busy), .done(done),
        .fail(fail)
    );

    int errors = 0;
    int checks = 0;
    logic [DW-1:0] seed = 16'h0;
    int need [NW];
    int bad_sel = -1;
    int bad_addr = -1;
    logic clr = 1'b0;

    logic [DW-1:0] mem [NW];
    int cnt [NW];
    int reads_hi, reads_lo, order_err;
    int v_r2, v_r3, v_r4, v_r5, pulses;

    function automatic logic [DW-1:0] patf(input logic [AW-1:0] a);
        return seed ^ (16'h1357 * (16'(a) + 16'd1));
    endfunction

    assign pat_i  = patf(addr_o);
    assign data_i = (!ce_n && !oe_n && pgm_n)
                    ? (mem[addr_o] ^ ((int'(vcc_sel) == bad_sel && int'(addr_o) == bad_addr)
                                      ? 16'h0001 : 16'h0000))
                    : 16'h0000;

    // Monitor and memory model, sampled on the falling edge.
    logic p_pgm = 1'b1, p_doe = 1'b0, p_oe = 1'b1;
    logic [AW-1:0] p_addr = '0;
    logic [DW-1:0] p_data = '0;
    int lowcnt = 0, stc = 0, hcnt = 0, rcnt = 0;
    always @(negedge clk) begin
        if (clr) begin
            for (int i = 0; i < NW; i++) begin mem[i] = 16'hFFFF; cnt[i] = 0; end
            reads_hi = 0; reads_lo = 0; order_err = 0;
            v_r2 = 0; v_r3 = 0; v_r4 = 0; v_r5 = 0; pulses = 0;
        end else if (rst_n) begin
            if (!pgm_n) begin
                lowcnt++;
                if (ce_n || !oe_n || !vpp_hi || vcc_sel != 2'b01 || !data_oe || data_o != patf(addr_o))
                    v_r3++;
                if (p_pgm && stc < GCYC) v_r4++;
                if (!p_pgm && (addr_o != p_addr || data_o != p_data)) v_r4++;
                hcnt = 0;
            end else begin
                if (!p_pgm) begin
                    pulses++;
                    if (lowcnt != PCYC) v_r2++;
                    cnt[addr_o]++;
                    if (cnt[addr_o] == need[addr_o]) mem[addr_o] = mem[addr_o] & patf(addr_o);
                end
                lowcnt = 0;
                if (!ce_n && vpp_hi && data_oe)
                    stc = (p_doe && addr_o == p_addr && data_o == p_data) ? stc + 1 : 1;
                else
                    stc = 0;
                if (data_oe) begin
                    if (data_o == p_data || !p_doe) hcnt++; else hcnt = 0;
                end
            end
            if (p_doe && !data_oe && hcnt < GCYC) v_r4++;
            if (data_oe) rcnt = 0; else if (oe_n) rcnt++;
            if (p_oe && !oe_n && vpp_hi && rcnt < GCYC) v_r5++;
            if (!oe_n && data_oe) v_r5++;
            if (!oe_n && !vpp_hi) begin
                if (vcc_sel == 2'b10) begin
                    if (int'(addr_o) != reads_hi || reads_lo != 0) order_err++;
                    reads_hi++;
                end else if (vcc_sel == 2'b11) begin
                    if (int'(addr_o) != reads_lo) order_err++;
                    reads_lo++;
                end else order_err++;
            end
        end
        p_pgm = pgm_n; p_doe = data_oe; p_oe = oe_n; p_addr = addr_o; p_data = data_o;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic launch(input logic [DW-1:0] sd, input int bs, input int ba);
        seed = sd; bad_sel = bs; bad_addr = ba;
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(busy === 1'b1, "R1 busy after start", int'(busy), 1);
    endtask

    task automatic finish_wait();
        while (!(done || fail)) @(negedge clk);
    endtask

    task automatic common_timing(input string nm);
        chk(v_r2 == 0, {"R2 strobe width ", nm}, v_r2, 0);
        chk(v_r3 == 0, {"R3 strobe conditions ", nm}, v_r3, 0);
        chk(v_r4 == 0, {"R4 setup/hold ", nm}, v_r4, 0);
        chk(v_r5 == 0, {"R5 release/read ", nm}, v_r5, 0);
        chk(order_err == 0, {"R8 read order ", nm}, order_err, 0);
    endtask

    initial begin : wdog
        repeat (190000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        int bad;
        for (int i = 0; i < NW; i++) need[i] = 1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle pin state
        chk(ce_n && oe_n && pgm_n && !data_oe && !vpp_hi, "R1 idle pins",
            {ce_n, oe_n, pgm_n, data_oe, vpp_hi}, 5'b11100);
        chk(vcc_sel == 2'b00 && !busy && !done && !fail, "R1 idle status",
            {vcc_sel, busy, done, fail}, 0);

        // Run 1: every word takes one strobe
        launch(16'hA5C3, -1, -1);
        finish_wait();
        chk(done && !fail && !busy, "R8 done after clean run", {done, fail, busy}, 3'b100);
        chk(pulses == NW, "R6 one strobe per word", pulses, NW);
        bad = 0;
        for (int i = 0; i < NW; i++) if (mem[i] != patf(AW'(i))) bad++;
        chk(bad == 0, "R6 array contents", bad, 0);
        chk(reads_hi == NW && reads_lo == NW, "R8 read counts", reads_hi * 100 + reads_lo, NW * 101);
        common_timing("run1");

        // Run 2: varied needs up to the limit; start pulsed mid-run (R10)
        for (int i = 0; i < NW; i++) need[i] = (i * 7) % MAXP + 1;
        launch(16'h3C0F, -1, -1);
        repeat (700) @(negedge clk);
        start = 1'b1; @(negedge clk); start = 1'b0;
        finish_wait();
        chk(done && !fail, "R10 restart after done and ignore mid-run start", {done, fail}, 2'b10);
        bad = 0;
        for (int i = 0; i < NW; i++) if (cnt[i] != need[i]) bad++;
        chk(bad == 0, "R6 exact strobe count per word", bad, 0);
        chk(cnt[7] == MAXP, "R6 word needing the limit passes", cnt[7], MAXP);
        chk(reads_hi == NW && reads_lo == NW, "R8 read counts run2", reads_hi * 100 + reads_lo, NW * 101);
        common_timing("run2");

        // Run 3: word 3 never verifies within the limit
        for (int i = 0; i < NW; i++) need[i] = 2;
        need[3] = MAXP + 1;
        launch(16'h0F0F, -1, -1);
        finish_wait();
        repeat (20) @(negedge clk);
        chk(fail && !done && !busy, "R7 fail on retry limit", {fail, done, busy}, 3'b100);
        chk(cnt[3] == MAXP, "R7 strobes at failing word", cnt[3], MAXP);
        bad = 0;
        for (int i = 4; i < NW; i++) bad += cnt[i];
        chk(bad == 0, "R7 no later strobes", bad, 0);
        chk(reads_hi + reads_lo == 0, "R7 no check reads", reads_hi + reads_lo, 0);
        common_timing("run3");

        // Run 4: mismatch at 2.7 V on word 5
        for (int i = 0; i < NW; i++) need[i] = 1;
        launch(16'h7E81, 3, 5);
        finish_wait();
        chk(fail && !done, "R9 fail in low-supply check", {fail, done}, 2'b10);
        chk(reads_hi == NW, "R9 full 5 V pass first", reads_hi, NW);
        chk(reads_lo == 6, "R9 stops at bad word", reads_lo, 6);

        // Run 5: mismatch at 5 V on word 0
        launch(16'h1248, 2, 0);
        finish_wait();
        chk(fail && !done, "R9 fail in 5 V check", {fail, done}, 2'b10);
        chk(reads_hi == 1 && reads_lo == 0, "R9 single read before stop",
            reads_hi * 100 + reads_lo, 100);
        common_timing("run5");

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule